// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block steps through a list of scatter-gather descriptors held in host memory and feeds one address/length pair at a time to a data mover. It keeps a working segment count, a pointer to the next descriptor and a flag that suppresses the next descriptor load. At the start of each data phase it either fetches a 12-byte descriptor over a one-byte-per-cycle read stream, or it presents the address and length it already holds.

When the data mover reports the end of a transfer, the block reads the residual byte count. A zero residual moves the walker on to the next descriptor. A nonzero residual means the transfer stopped part-way through the segment. In that case the walker keeps the segment, records the end address and the residual as the point to resume from, and does not load a descriptor on the next phase. The working state can be written out to a per-command context and read back from it, so that a command can be suspended and resumed later.

Top module: `sg_walker`

## Requirements
- R1: After reset, `seg_valid`, `fetch_busy`, `rd_req` and `ctx_wr` are 0, `ctx_cnt_o` and `ctx_ptr_o` are 0, and `ctx_reload_o` is 1 (no-reload flag clear).
- R2: An accepted `phase_start` with a nonzero count and the no-reload flag clear raises `rd_req` for exactly one cycle on the next cycle, with `rd_addr` equal to the pointer. `fetch_busy` is high from that cycle until the cycle after the twelfth byte is taken. A byte is taken on each cycle where `rd_valid` is high.
- R3: Descriptor bytes 0..3 form `seg_addr` and bytes 8..10 form `seg_len`, both least significant byte first. Bytes 4..7 and byte 11 have no effect. `seg_valid` rises one cycle after `fetch_busy` falls.
- R4: An accepted `phase_start` with a zero count or the no-reload flag set issues no `rd_req`. On the next cycle it raises `seg_valid` with the held `seg_addr`/`seg_len`.
- R5: `seg_wide_odd` is high exactly when `seg_valid` is high and the working count is 2 or more, meaning at least one segment follows the current one.
- R6: An accepted `xfer_done` with `xfer_resid` zero and a nonzero count decrements the count, clears the no-reload flag and adds 12 to the 32-bit pointer, with the carry running through all 32 bits.
- R7: An accepted `xfer_done` with a nonzero `xfer_resid` sets the no-reload flag and loads `seg_addr` from `xfer_addr` and `seg_len` from `xfer_resid`. The count and the pointer stay unchanged. The next phase presents these values without a fetch.
- R8: Every accepted `xfer_done` drops `seg_valid` and pulses `ctx_wr` on the next cycle, with `ctx_cnt_o` holding the updated count.
- R9: `ctx_save` pulses `ctx_wr` on the next cycle. At that point `ctx_cnt_o`, `ctx_ptr_o`, `seg_addr` and `seg_len` hold the working values, and `ctx_reload_o` is the inverse of the no-reload flag.
- R10: `ctx_restore`, when no fetch is running and `seg_valid` is low, loads the count, pointer, address and length from the context inputs and sets the no-reload flag to the inverse of `ctx_reload_i`. `ctx_restore` has priority over a `phase_start` in the same cycle. A restore at any other time is ignored.
- R11: `xfer_done` is ignored while a fetch is running or while `seg_valid` is low. An ignored `xfer_done` pulses no `ctx_wr` and changes no state.
- R12: `phase_start` is ignored while a fetch is running or while `seg_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_start | input | 1 | Data phase begins, segment wanted |
| xfer_done | input | 1 | Data mover finished the current segment |
| xfer_resid | input | 24 | Bytes left untransferred |
| xfer_addr | input | 32 | Address reached by the data mover |
| rd_req | output | 1 | One-cycle request for a 12-byte descriptor read |
| rd_addr | output | 32 | Host address of the descriptor |
| rd_valid | input | 1 | Descriptor byte present |
| rd_data | input | 8 | Descriptor byte |
| fetch_busy | output | 1 | Descriptor read in progress |
| seg_valid | output | 1 | Segment address/length valid for the data mover |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 24 | Segment length in bytes |
| seg_wide_odd | output | 1 | More segments follow the current one |
| ctx_save | input | 1 | Write working state to context |
| ctx_restore | input | 1 | Load working state from context |
| ctx_cnt_i | input | CNT_W | Restored segment count |
| ctx_ptr_i | input | 32 | Restored descriptor pointer |
| ctx_reload_i | input | 1 | Restored reload-needed record |
| ctx_addr_i | input | 32 | Restored segment address |
| ctx_len_i | input | 24 | Restored segment length |
| ctx_wr | output | 1 | Context write strobe |
| ctx_cnt_o | output | CNT_W | Working segment count |
| ctx_ptr_o | output | 32 | Working descriptor pointer |
| ctx_reload_o | output | 1 | Reload-needed record |

## Verification
The walk is driven from restored states in several ways. One case has several segments left, one has the last segment, and one has a pointer that wraps past 2^32. These cases tell a correct decrement and carry apart from a pointer that loses bits and from a wide-odd indication that is off by one. A nonzero residual followed by a second phase shows whether the walker resumes the segment or loads a descriptor it should have skipped. A zero count and a restored no-reload record show whether each condition suppresses the fetch on its own. Descriptors have distinct byte values, including the unused bytes, and arrive with a stall in the middle. Together with a `xfer_done`, a `phase_start` and a `ctx_restore` injected during the fetch, these expose byte-order faults, byte-count faults and missing input gating.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int unsigned DESC_BYTES = 12;
  localparam int unsigned IDX_W      = $clog2(DESC_BYTES);
  localparam int unsigned LEN_BYTES  = 3;
  localparam int unsigned LEN_FIRST  = 8;

  // Pointer step to the following descriptor, full 32-bit carry.
  function automatic logic [31:0] sg_ptr_step(input logic [31:0] p);
    return p + 32'(DESC_BYTES);
  endfunction

  // Place one descriptor byte into the address word (bytes 0..3).
  function automatic logic [31:0] sg_addr_merge(input logic [31:0] cur,
                                                input logic [IDX_W-1:0] idx,
                                                input logic [7:0] b);
    logic [31:0] r;
    r = cur;
    for (int k = 0; k < 4; k++)
      if (idx == IDX_W'(k)) r[8*k +: 8] = b;
    return r;
  endfunction

  // Place one descriptor byte into the length word (bytes 8..10).
  function automatic logic [23:0] sg_len_merge(input logic [23:0] cur,
                                               input logic [IDX_W-1:0] idx,
                                               input logic [7:0] b);
    logic [23:0] r;
    r = cur;
    for (int k = 0; k < LEN_BYTES; k++)
      if (idx == IDX_W'(LEN_FIRST + k)) r[8*k +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/sg_fetch.sv
module sg_fetch
  import sg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] base_i,
  input  logic        rd_valid_i,
  input  logic [7:0]  rd_data_i,
  output logic        rd_req_o,
  output logic [31:0] rd_addr_o,
  output logic        busy_o,
  output logic        last_o,
  output logic        done_o,
  output logic [31:0] addr_o,
  output logic [23:0] len_o
);
  logic [IDX_W-1:0] idx_q;
  logic             take;

  assign take   = busy_o && rd_valid_i;
  assign last_o = take && (idx_q == IDX_W'(DESC_BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      idx_q     <= '0;
      addr_o    <= '0;
      len_o     <= '0;
    end else begin
      rd_req_o <= 1'b0;
      done_o   <= 1'b0;
      if (start_i) begin
        rd_req_o  <= 1'b1;
        rd_addr_o <= base_i;
        busy_o    <= 1'b1;
        idx_q     <= '0;
      end else if (take) begin
        addr_o <= sg_addr_merge(addr_o, idx_q, rd_data_i);
        len_o  <= sg_len_merge(len_o, idx_q, rd_data_i);
        if (last_o) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sg_track.sv
module sg_track
  import sg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restore_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [31:0]      ptr_i,
  input  logic             reload_i,
  input  logic             done_i,
  input  logic             resid_zero_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [31:0]      ptr_o,
  output logic             noload_o
);
  logic advance;
  assign advance = done_i && resid_zero_i && (cnt_o != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o    <= '0;
      ptr_o    <= '0;
      noload_o <= 1'b0;
    end else if (restore_i) begin
      cnt_o    <= cnt_i;
      ptr_o    <= ptr_i;
      noload_o <= !reload_i;
    end else if (advance) begin
      cnt_o    <= cnt_o - CNT_W'(1);
      ptr_o    <= sg_ptr_step(ptr_o);
      noload_o <= 1'b0;
    end else if (done_i && !resid_zero_i) begin
      noload_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_start,
  input  logic             xfer_done,
  input  logic [23:0]      xfer_resid,
  input  logic [31:0]      xfer_addr,
  output logic             rd_req,
  output logic [31:0]      rd_addr,
  input  logic             rd_valid,
  input  logic [7:0]       rd_data,
  output logic             fetch_busy,
  output logic             seg_valid,
  output logic [31:0]      seg_addr,
  output logic [23:0]      seg_len,
  output logic             seg_wide_odd,
  input  logic             ctx_save,
  input  logic             ctx_restore,
  input  logic [CNT_W-1:0] ctx_cnt_i,
  input  logic [31:0]      ctx_ptr_i,
  input  logic             ctx_reload_i,
  input  logic [31:0]      ctx_addr_i,
  input  logic [23:0]      ctx_len_i,
  output logic             ctx_wr,
  output logic [CNT_W-1:0] ctx_cnt_o,
  output logic [31:0]      ctx_ptr_o,
  output logic             ctx_reload_o
);
  // Named internal events, also observed by the checker.
  logic             restore_acc, start_acc, done_acc, need_fetch;
  logic             fetch_start, fetch_last, fetch_done, noload;
  logic [31:0]      f_addr;
  logic [23:0]      f_len;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      ptr;

  assign restore_acc = ctx_restore && !fetch_busy && !seg_valid;
  assign start_acc   = phase_start && !fetch_busy && !seg_valid && !restore_acc;
  assign done_acc    = xfer_done && seg_valid && !fetch_busy;
  assign need_fetch  = (cnt != '0) && !noload;
  assign fetch_start = start_acc && need_fetch;

  sg_fetch u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (fetch_start),
    .base_i     (ptr),
    .rd_valid_i (rd_valid),
    .rd_data_i  (rd_data),
    .rd_req_o   (rd_req),
    .rd_addr_o  (rd_addr),
    .busy_o     (fetch_busy),
    .last_o     (fetch_last),
    .done_o     (fetch_done),
    .addr_o     (f_addr),
    .len_o      (f_len)
  );

  sg_track #(.CNT_W(CNT_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .restore_i    (restore_acc),
    .cnt_i        (ctx_cnt_i),
    .ptr_i        (ctx_ptr_i),
    .reload_i     (ctx_reload_i),
    .done_i       (done_acc),
    .resid_zero_i (xfer_resid == '0),
    .cnt_o        (cnt),
    .ptr_o        (ptr),
    .noload_o     (noload)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_valid <= 1'b0;
      seg_addr  <= '0;
      seg_len   <= '0;
      ctx_wr    <= 1'b0;
    end else begin
      ctx_wr <= ctx_save || done_acc;
      if (restore_acc) begin
        seg_addr <= ctx_addr_i;
        seg_len  <= ctx_len_i;
      end else if (done_acc) begin
        seg_valid <= 1'b0;
        if (xfer_resid != '0) begin
          seg_addr <= xfer_addr;
          seg_len  <= xfer_resid;
        end
      end else if (fetch_done) begin
        seg_valid <= 1'b1;
        seg_addr  <= f_addr;
        seg_len   <= f_len;
      end else if (start_acc && !need_fetch) begin
        seg_valid <= 1'b1;
      end
    end
  end

  assign seg_wide_odd = seg_valid && (cnt > CNT_W'(1));
  assign ctx_cnt_o    = cnt;
  assign ctx_ptr_o    = ptr;
  assign ctx_reload_o = !noload;
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_acc,
  input logic             done_acc,
  input logic             need_fetch,
  input logic             fetch_last,
  input logic             rd_req,
  input logic             fetch_busy,
  input logic             seg_valid,
  input logic [23:0]      seg_len,
  input logic [23:0]      xfer_resid,
  input logic             ctx_wr,
  input logic [CNT_W-1:0] ctx_cnt_o,
  input logic [31:0]      ctx_ptr_o,
  input logic             ctx_reload_o
);
  // R2: a request always coincides with an open fetch
  p_req_in_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> fetch_busy);

  // R2: the fetch stays open until the twelfth byte
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_busy && !fetch_last |=> fetch_busy);

  // R2: an accepted phase needing a descriptor requests it
  p_fetch_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && need_fetch |=> rd_req);

  // R4: skipped fetch presents the held segment directly
  p_skip_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc && !need_fetch |=> seg_valid && !rd_req);

  // R6: zero residual advances count and pointer
  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc && xfer_resid == 24'd0 && ctx_cnt_o != '0 |=>
      ctx_cnt_o == $past(ctx_cnt_o) - CNT_W'(1) &&
      ctx_ptr_o == $past(ctx_ptr_o) + 32'd12 && ctx_reload_o);

  // R7: nonzero residual holds position and keeps the residual
  p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc && xfer_resid != 24'd0 |=>
      !ctx_reload_o && $stable(ctx_cnt_o) && $stable(ctx_ptr_o) &&
      seg_len == $past(xfer_resid));

  // R8: every accepted completion writes the context
  p_ctx_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> ctx_wr && !seg_valid);

  // R11: nothing moves the count or pointer during a fetch
  p_busy_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_busy |=> $stable(ctx_cnt_o) && $stable(ctx_ptr_o));
endmodule

bind sg_walker sg_walker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_acc    (start_acc),
  .done_acc     (done_acc),
  .need_fetch   (need_fetch),
  .fetch_last   (fetch_last),
  .rd_req       (rd_req),
  .fetch_busy   (fetch_busy),
  .seg_valid    (seg_valid),
  .seg_len      (seg_len),
  .xfer_resid   (xfer_resid),
  .ctx_wr       (ctx_wr),
  .ctx_cnt_o    (ctx_cnt_o),
  .ctx_ptr_o    (ctx_ptr_o),
  .ctx_reload_o (ctx_reload_o)
);

// File: tb/test_sg_walker.sv
module test_sg_walker;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          phase_start = 1'b0, xfer_done = 1'b0;
  logic [23:0]   xfer_resid = '0;
  logic [31:0]   xfer_addr = '0;
  logic          rd_req;
  logic [31:0]   rd_addr;
  logic          rd_valid = 1'b0;
  logic [7:0]    rd_data = '0;
  logic          fetch_busy, seg_valid, seg_wide_odd;
  logic [31:0]   seg_addr;
  logic [23:0]   seg_len;
  logic          ctx_save = 1'b0, ctx_restore = 1'b0;
  logic [CW-1:0] ctx_cnt_i = '0;
  logic [31:0]   ctx_ptr_i = '0;
  logic          ctx_reload_i = 1'b0;
  logic [31:0]   ctx_addr_i = '0;
  logic [23:0]   ctx_len_i = '0;
  logic          ctx_wr;
  logic [CW-1:0] ctx_cnt_o;
  logic [31:0]   ctx_ptr_o;
  logic          ctx_reload_o;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sg_walker #(.CNT_W(CW)) i_sg_walker (.*);

  // Vector table: restored count, pointer, reload record, residual.
  localparam int NV = 6;
  localparam logic [7:0]  V_CNT [NV] = '{8'd3, 8'd1, 8'd2, 8'd4, 8'd2, 8'd0};
  localparam logic [31:0] V_PTR [NV] = '{32'h0000_1000, 32'h0000_20F8,
    32'hFFFF_FFF8, 32'h0000_3000, 32'h0000_4000, 32'h0000_5000};
  localparam logic        V_RLD [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [23:0] V_RES [NV] = '{24'd0, 24'd0, 24'd0, 24'h000123,
    24'd0, 24'd0};

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] d_addr(input logic [31:0] p);
    return p + 32'h1357_9BDF;
  endfunction
  function automatic logic [23:0] d_len(input logic [31:0] p);
    return 24'hC0FFEE ^ {p[7:0], 16'h0};
  endfunction
  function automatic logic [7:0] d_byte(input int i, input logic [31:0] a,
                                        input logic [23:0] l);
    if (i < 4) return a[8*i +: 8];
    if (i < 8) return 8'hE0 + 8'(i);
    if (i < 11) return l[8*(i-8) +: 8];
    return 8'h77;
  endfunction

  task automatic feed(input int first, input int last, input logic [31:0] a,
                      input logic [23:0] l);
    for (int i = first; i <= last; i++) begin
      rd_valid = 1'b1;
      rd_data  = d_byte(i, a, l);
      tick();
    end
    rd_valid = 1'b0;
  endtask

  task automatic restore(input logic [7:0] c, input logic [31:0] p,
                         input logic r, input logic [31:0] a,
                         input logic [23:0] l);
    ctx_restore = 1'b1; ctx_cnt_i = c; ctx_ptr_i = p; ctx_reload_i = r;
    ctx_addr_i = a; ctx_len_i = l;
    tick();
    ctx_restore = 1'b0;
  endtask

  task automatic start_phase();
    phase_start = 1'b1;
    tick();
    phase_start = 1'b0;
  endtask

  task automatic finish_xfer(input logic [23:0] r, input logic [31:0] a);
    xfer_done = 1'b1; xfer_resid = r; xfer_addr = a;
    tick();
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] ea, ra, dna;
    logic [23:0] el, rl;
    logic        fetch;
    tick(); tick();
    // R1 reset state
    chk(!seg_valid && !fetch_busy && !rd_req && !ctx_wr, "R1 outputs idle",
        {seg_valid, fetch_busy, rd_req, ctx_wr}, 0);
    chk(ctx_cnt_o == 0 && ctx_ptr_o == 0 && ctx_reload_o, "R1 state",
        {ctx_cnt_o, ctx_ptr_o, ctx_reload_o}, 1);
    rst_n = 1'b1;
    tick();

    for (int v = 0; v < NV; v++) begin
      ra = V_PTR[v] ^ 32'h0F0F_0000;
      rl = 24'h000400 + 24'(V_CNT[v]);
      restore(V_CNT[v], V_PTR[v], V_RLD[v], ra, rl);
      chk(ctx_cnt_o == V_CNT[v] && ctx_ptr_o == V_PTR[v] &&
          ctx_reload_o == V_RLD[v], "R10 restore", ctx_ptr_o, V_PTR[v]);
      fetch = (V_CNT[v] != 0) && V_RLD[v];
      start_phase();
      if (fetch) begin
        ea = d_addr(V_PTR[v]); el = d_len(V_PTR[v]);
        chk(rd_req && rd_addr == V_PTR[v] && fetch_busy, "R2 request",
            rd_addr, V_PTR[v]);
        feed(0, 11, ea, el);
        chk(!fetch_busy && !seg_valid, "R2 busy falls", fetch_busy, 0);
        tick();
        chk(!rd_req, "R2 single pulse", rd_req, 0);
      end else begin
        ea = ra; el = rl;
        chk(!rd_req && !fetch_busy, "R4 no fetch", rd_req, 0);
      end
      chk(seg_valid && seg_addr == ea, "R3 address", seg_addr, ea);
      chk(seg_len == el, "R3 length", seg_len, el);
      chk(seg_wide_odd == (V_CNT[v] > 1), "R5 wide odd", seg_wide_odd,
          V_CNT[v] > 1);
      dna = ea + 32'h40;
      finish_xfer(V_RES[v], dna);
      chk(ctx_wr && !seg_valid, "R8 context write", ctx_wr, 1);
      if (V_RES[v] == 0 && V_CNT[v] != 0) begin
        chk(ctx_cnt_o == V_CNT[v] - 1 && ctx_reload_o, "R6 count",
            ctx_cnt_o, V_CNT[v] - 1);
        chk(ctx_ptr_o == V_PTR[v] + 32'd12, "R6 pointer", ctx_ptr_o,
            V_PTR[v] + 32'd12);
      end else if (V_RES[v] != 0) begin
        chk(ctx_cnt_o == V_CNT[v] && ctx_ptr_o == V_PTR[v] && !ctx_reload_o,
            "R7 hold", ctx_ptr_o, V_PTR[v]);
        chk(seg_addr == dna && seg_len == V_RES[v], "R7 resume point",
            seg_len, V_RES[v]);
        // R7: the next phase resumes without a descriptor read
        start_phase();
        chk(!rd_req && seg_valid && seg_addr == dna && seg_len == V_RES[v],
            "R7 resume phase", seg_addr, dna);
        finish_xfer(24'd0, dna + 32'h123);
        chk(ctx_cnt_o == V_CNT[v] - 1 && ctx_reload_o &&
            ctx_ptr_o == V_PTR[v] + 32'd12, "R6 after resume", ctx_cnt_o,
            V_CNT[v] - 1);
      end else begin
        chk(ctx_cnt_o == 0 && ctx_ptr_o == V_PTR[v] && ctx_reload_o,
            "R6 empty list unchanged", ctx_ptr_o, V_PTR[v]);
      end
      tick();
      chk(!ctx_wr, "R8 single pulse", ctx_wr, 0);
    end

    // Directed: gating during a stalled fetch (R10, R11, R12)
    restore(8'd2, 32'h0000_0600, 1'b1, 32'h0, 24'h0);
    start_phase();
    ea = d_addr(32'h600); el = d_len(32'h600);
    feed(0, 5, ea, el);
    xfer_done = 1'b1; xfer_resid = 24'h55;
    tick();
    xfer_done = 1'b0;
    chk(!ctx_wr && fetch_busy, "R11 done ignored in fetch", ctx_wr, 0);
    phase_start = 1'b1;
    ctx_restore = 1'b1; ctx_cnt_i = 8'd9; ctx_ptr_i = 32'hDEAD_0000;
    tick();
    phase_start = 1'b0; ctx_restore = 1'b0;
    chk(!rd_req, "R12 start ignored in fetch", rd_req, 0);
    feed(6, 11, ea, el);
    tick();
    chk(seg_valid && seg_addr == ea && seg_len == el, "R3 stalled fetch",
        seg_addr, ea);
    chk(ctx_cnt_o == 2 && ctx_ptr_o == 32'h600 && ctx_reload_o,
        "R10 restore ignored in fetch", ctx_ptr_o, 32'h600);
    start_phase();
    chk(!rd_req && seg_addr == ea, "R12 start ignored while valid", rd_req, 0);
    // R9 save while a segment is held
    ctx_save = 1'b1;
    tick();
    ctx_save = 1'b0;
    chk(ctx_wr && ctx_cnt_o == 2 && ctx_ptr_o == 32'h600 && ctx_reload_o &&
        seg_addr == ea && seg_len == el, "R9 save", ctx_cnt_o, 2);
    finish_xfer(24'd0, 32'h0);
    tick();
    // R11: done with no valid segment is ignored
    finish_xfer(24'h10, 32'h99);
    chk(!ctx_wr && ctx_cnt_o == 1 && ctx_reload_o, "R11 done while idle",
        ctx_cnt_o, 1);
    // R10 restore with no-reload record, R4 skip by flag
    restore(8'd5, 32'h0000_7000, 1'b0, 32'hAAAA_0000, 24'h000777);
    chk(!ctx_reload_o, "R10 reload record", ctx_reload_o, 0);
    start_phase();
    chk(!rd_req && seg_valid && seg_addr == 32'hAAAA_0000 &&
        seg_len == 24'h777 && seg_wide_odd, "R4 skip by flag", seg_len,
        24'h777);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule